// File: doc/BRIEF.md
# Register-Staged Single Transaction Bridge

This block lets a host processor push one transaction at a time onto a downstream peripheral bus. The host stages the parameters of the transfer in separate registers through a simple 32-bit register port: the direction, the transfer size, the target address and the write data. A write to the launch register then starts the transfer. The block drives a request/acknowledge master toward the downstream side, waits for the response, and records the outcome in a status word. For reads it also stores the returned data.

Completion is reported in two places. A sticky channel acknowledge bit is set in an interrupt status register, and it can be routed to the interrupt output through a mask. The host clears this bit by writing 1 to the clear register before it launches the next transfer. The downstream side may answer with a retry. The block then drops its request for one cycle and reissues it, up to a programmable number of times. When that count runs out, the block completes with a timeout flag set. Only channel 0 exists, and its select bit must be set for a launch to be accepted.

Top module: `xact_bridge`

## Requirements
- R1: After reset the status word, read data, interrupt status, interrupt mask and all staging registers read 0, the version register reads the VERSION parameter, and dn_req and irq are low.
- R2: Register offsets and their stored widths:
  - 0x08 control base (32 bits) and 0x0C link base (32 bits);
  - 0x10 select (bit 0), 0x14 direction (bit 0), 0x18 size (bits 1:0);
  - 0x1C address (32 bits) and 0x20 write data (32 bits);
  - 0x3C clock sync (bit 0), 0x44 interrupt mask (bit 16 only), 0x64 retry limit (bits 7:0).
  - Each reads back what was written, masked to these bits. Unmapped offsets read 0.
- R3: Launch behaviour:
  - Writing a value with bit 0 set to offset 0x04 while idle and with select = 1 raises dn_req on the next cycle.
  - dn_rnw equals the direction register (1 = read, 0 = write). dn_size equals the size register (0 = byte, 1 = halfword, 3 = fullword). dn_addr and dn_wdata equal the staged values.
  - All of these hold steady until dn_ack.
- R4: A launch write is ignored when select is 0, when bit 0 of the written value is 0, or while a transfer is in flight. An ignored launch starts no request and does not alter the transfer in progress.
- R5: Bit 31 of the status word (offset 0x80) reads 1 from the cycle after an accepted launch until the final acknowledge.
- R6: Status bits are recorded on completion:
  - dn_resp 0 (ok) sets bit 1 for size 2 or 3, and bit 0 for size 0 or 1.
  - dn_resp 1 (error) sets bit 2.
  - At most one of bits 2:0 is set.
- R7: Retry handling:
  - dn_resp 2 (retry) with fewer reissues used than the retry limit drops dn_req for exactly one cycle, then reissues the request and sets status bit 3.
  - A retry answered after the limit is used up completes the transfer with bits 3 and 4 set.
- R8: Read data and status are cleared by an accepted launch and otherwise hold. On an ok read, offset 0x84 returns dn_rdata zero-extended: bits 7:0 for size 0, bits 15:0 for size 1, the full word otherwise. Writes and failed reads leave 0 there.
- R9: Interrupt status bit 16 (offset 0x48) is set when a transfer completes. A write to offset 0x40 with bit 0 set clears it, and a write with bit 0 clear does not. A completion in the same cycle as a clear leaves the bit set.
- R10: irq is high exactly when interrupt status bit 16 and mask bit 16 are both set. Bit 17 reads 0 in both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_wr | input | 1 | Host register write strobe |
| hst_addr | input | 8 | Host register byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for hst_addr (combinational) |
| irq | output | 1 | Masked completion interrupt |
| dn_req | output | 1 | Downstream request, held until dn_ack |
| dn_rnw | output | 1 | Downstream direction, 1 = read |
| dn_size | output | 2 | Downstream transfer size code |
| dn_addr | output | 32 | Downstream target address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge, one cycle |
| dn_resp | input | 2 | Response with dn_ack: 0 ok, 1 error, 2 retry |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
The bench sweeps every combination of direction, all four size codes and ok/error responses, computing the expected status and zero-extended read data. A design that mixes up the narrow and full acknowledge bits, or leaks upper bytes on narrow reads, fails there. It also sweeps retry limits 0 to 3 against every retry count up to one past the limit. This catches an off-by-one in the reissue budget, a missing one-cycle gap, and a timeout that never completes. Launches with select clear, with bit 0 clear, and during a transfer that a second launch would otherwise overwrite are all checked at dn_req and dn_addr. A clear write that lands in the same cycle as a completion is checked to confirm that the completion is not lost.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int unsigned HOST_AW = 8;

  localparam logic [HOST_AW-1:0] OFS_VER   = 8'h00;
  localparam logic [HOST_AW-1:0] OFS_TRIG  = 8'h04;
  localparam logic [HOST_AW-1:0] OFS_CBASE = 8'h08;
  localparam logic [HOST_AW-1:0] OFS_LBASE = 8'h0C;
  localparam logic [HOST_AW-1:0] OFS_SEL   = 8'h10;
  localparam logic [HOST_AW-1:0] OFS_DIR   = 8'h14;
  localparam logic [HOST_AW-1:0] OFS_SIZE  = 8'h18;
  localparam logic [HOST_AW-1:0] OFS_ADDR  = 8'h1C;
  localparam logic [HOST_AW-1:0] OFS_WDAT  = 8'h20;
  localparam logic [HOST_AW-1:0] OFS_CSYNC = 8'h3C;
  localparam logic [HOST_AW-1:0] OFS_ICLR  = 8'h40;
  localparam logic [HOST_AW-1:0] OFS_IMSK  = 8'h44;
  localparam logic [HOST_AW-1:0] OFS_ISTA  = 8'h48;
  localparam logic [HOST_AW-1:0] OFS_RTRY  = 8'h64;
  localparam logic [HOST_AW-1:0] OFS_STAT  = 8'h80;
  localparam logic [HOST_AW-1:0] OFS_RDAT  = 8'h84;

  localparam int unsigned IRQ_CH0_BIT = 16;
  localparam int unsigned ST_HALF = 0;
  localparam int unsigned ST_FULL = 1;
  localparam int unsigned ST_ERR  = 2;
  localparam int unsigned ST_RTY  = 3;
  localparam int unsigned ST_TMO  = 4;
  localparam int unsigned ST_W    = 5;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_ERR   = 2'd1,
    RSP_RETRY = 2'd2
  } resp_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_GAP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/xb_rstsync.sv
module xb_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shft_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shft_q <= '0;
    else         shft_q <= {shft_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shft_q[STAGES-1];
endmodule

// File: rtl/xb_rdfmt.sv
module xb_rdfmt #(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    size,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam logic [DW-1:0] MASK_B = {{(DW-8){1'b0}}, 8'hFF};
  localparam logic [DW-1:0] MASK_H = {{(DW-16){1'b0}}, 16'hFFFF};

  logic [DW-1:0] lane_mask;

  always_comb begin
    case (size)
      2'd0:    lane_mask = MASK_B;
      2'd1:    lane_mask = MASK_H;
      default: lane_mask = '1;
    endcase
    dout = din & lane_mask;
  end
endmodule

// File: rtl/xb_seq.sv
module xb_seq
  import xb_pkg::*;
#(
  parameter int unsigned RCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch,
  input  logic [RCW-1:0] retry_lim,
  input  logic           ack,
  input  logic [1:0]     resp,
  output logic           req,
  output logic           busy,
  output logic           fin,
  output logic           fin_err,
  output logic           fin_tmo,
  output logic           fin_rty
);
  seq_state_e     state_q, state_d;
  logic [RCW-1:0] cnt_q, cnt_d;
  logic [RCW-1:0] lim_q;
  logic           rty_q, rty_d;
  logic           lim_ld;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rty_d   = rty_q;
    lim_ld  = 1'b0;
    fin     = 1'b0;
    fin_err = 1'b0;
    fin_tmo = 1'b0;
    fin_rty = rty_q;
    case (state_q)
      SQ_IDLE: begin
        if (launch) begin
          state_d = SQ_REQ;
          cnt_d   = '0;
          rty_d   = 1'b0;
          lim_ld  = 1'b1;
        end
      end
      SQ_REQ: begin
        if (ack) begin
          if (resp == RSP_RETRY) begin
            rty_d = 1'b1;
            if (cnt_q != lim_q) begin
              state_d = SQ_GAP;
              cnt_d   = cnt_q + 1'b1;
            end else begin
              state_d = SQ_IDLE;
              fin     = 1'b1;
              fin_tmo = 1'b1;
              fin_rty = 1'b1;
            end
          end else begin
            state_d = SQ_IDLE;
            fin     = 1'b1;
            fin_err = (resp != RSP_OK);
          end
        end
      end
      SQ_GAP:  state_d = SQ_REQ;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      rty_q   <= 1'b0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rty_q   <= rty_d;
      if (lim_ld) lim_q <= retry_lim;
    end
  end

  assign req  = (state_q == SQ_REQ);
  assign busy = (state_q != SQ_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req); // R3
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q <= lim_q); // R7
  AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && resp == RSP_RETRY && cnt_q != lim_q) |=> (!req && busy)); // R7
endmodule

// File: rtl/xact_bridge.sv
module xact_bridge
  import xb_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned DNAW    = 32,
  parameter int unsigned RCW     = 8,
  parameter logic [DW-1:0] VERSION = 32'h0001_0200
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               hst_wr,
  input  logic [HOST_AW-1:0] hst_addr,
  input  logic [DW-1:0]      hst_wdata,
  output logic [DW-1:0]      hst_rdata,
  output logic               irq,
  output logic               dn_req,
  output logic               dn_rnw,
  output logic [1:0]         dn_size,
  output logic [DNAW-1:0]    dn_addr,
  output logic [DW-1:0]      dn_wdata,
  input  logic               dn_ack,
  input  logic [1:0]         dn_resp,
  input  logic [DW-1:0]      dn_rdata
);
  logic rst_n;

  xb_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_sync(rst_n)
  );

  // staging registers
  logic [DW-1:0]   cbase_q, lbase_q, wdat_q;
  logic [DNAW-1:0] addr_q;
  logic            sel_q, dir_q, csync_q, imsk_q;
  logic [1:0]      size_q;
  logic [RCW-1:0]  rlim_q;
  // transfer shadow and results
  logic            x_rnw_q;
  logic [1:0]      x_size_q;
  logic [DNAW-1:0] x_addr_q;
  logic [DW-1:0]   x_wdat_q;
  logic [ST_W-1:0] stat_q, stat_d;
  logic [DW-1:0]   rdat_q, rdat_d, rd_fmt;
  logic            ista_q, ista_d;

  logic we_trig, we_cbase, we_lbase, we_sel, we_dir, we_size, we_addr;
  logic we_wdat, we_csync, we_iclr, we_imsk, we_rtry;
  logic launch, busy, fin, fin_err, fin_tmo, fin_rty, res_en;

  always_comb begin
    we_trig  = hst_wr && (hst_addr == OFS_TRIG);
    we_cbase = hst_wr && (hst_addr == OFS_CBASE);
    we_lbase = hst_wr && (hst_addr == OFS_LBASE);
    we_sel   = hst_wr && (hst_addr == OFS_SEL);
    we_dir   = hst_wr && (hst_addr == OFS_DIR);
    we_size  = hst_wr && (hst_addr == OFS_SIZE);
    we_addr  = hst_wr && (hst_addr == OFS_ADDR);
    we_wdat  = hst_wr && (hst_addr == OFS_WDAT);
    we_csync = hst_wr && (hst_addr == OFS_CSYNC);
    we_iclr  = hst_wr && (hst_addr == OFS_ICLR);
    we_imsk  = hst_wr && (hst_addr == OFS_IMSK);
    we_rtry  = hst_wr && (hst_addr == OFS_RTRY);
  end

  assign launch = we_trig && hst_wdata[0] && sel_q && !busy;

  xb_seq #(.RCW(RCW)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .retry_lim(rlim_q),
    .ack(dn_ack), .resp(dn_resp), .req(dn_req), .busy(busy),
    .fin(fin), .fin_err(fin_err), .fin_tmo(fin_tmo), .fin_rty(fin_rty)
  );

  xb_rdfmt #(.DW(DW)) u_fmt (
    .size(x_size_q), .din(dn_rdata), .dout(rd_fmt)
  );

  // staging register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbase_q <= '0;
      lbase_q <= '0;
      sel_q   <= 1'b0;
      dir_q   <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      csync_q <= 1'b0;
      imsk_q  <= 1'b0;
      rlim_q  <= '0;
    end else begin
      if (we_cbase) cbase_q <= hst_wdata;
      if (we_lbase) lbase_q <= hst_wdata;
      if (we_sel)   sel_q   <= hst_wdata[0];
      if (we_dir)   dir_q   <= hst_wdata[0];
      if (we_size)  size_q  <= hst_wdata[1:0];
      if (we_addr)  addr_q  <= hst_wdata[DNAW-1:0];
      if (we_wdat)  wdat_q  <= hst_wdata;
      if (we_csync) csync_q <= hst_wdata[0];
      if (we_imsk)  imsk_q  <= hst_wdata[IRQ_CH0_BIT];
      if (we_rtry)  rlim_q  <= hst_wdata[RCW-1:0];
    end
  end

  // transfer shadow: parameters frozen for the whole transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_rnw_q  <= 1'b0;
      x_size_q <= '0;
      x_addr_q <= '0;
      x_wdat_q <= '0;
    end else if (launch) begin
      x_rnw_q  <= dir_q;
      x_size_q <= size_q;
      x_addr_q <= addr_q;
      x_wdat_q <= wdat_q;
    end
  end

  // result capture next state
  always_comb begin
    stat_d = stat_q;
    rdat_d = rdat_q;
    res_en = launch || fin;
    if (launch) begin
      stat_d = '0;
      rdat_d = '0;
    end else if (fin) begin
      stat_d          = '0;
      stat_d[ST_ERR]  = fin_err;
      stat_d[ST_TMO]  = fin_tmo;
      stat_d[ST_RTY]  = fin_rty;
      stat_d[ST_HALF] = !fin_err && !fin_tmo && !x_size_q[1];
      stat_d[ST_FULL] = !fin_err && !fin_tmo && x_size_q[1];
      if (!fin_err && !fin_tmo && x_rnw_q) rdat_d = rd_fmt;
    end
    ista_d = ista_q;
    if (fin)                         ista_d = 1'b1;
    else if (we_iclr && hst_wdata[0]) ista_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      rdat_q <= '0;
      ista_q <= 1'b0;
    end else begin
      if (res_en) begin
        stat_q <= stat_d;
        rdat_q <= rdat_d;
      end
      ista_q <= ista_d;
    end
  end

  assign dn_rnw   = x_rnw_q;
  assign dn_size  = x_size_q;
  assign dn_addr  = x_addr_q;
  assign dn_wdata = x_wdat_q;
  assign irq      = ista_q && imsk_q;

  // host read mux
  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      OFS_VER:   hst_rdata = VERSION;
      OFS_CBASE: hst_rdata = cbase_q;
      OFS_LBASE: hst_rdata = lbase_q;
      OFS_SEL:   hst_rdata[0] = sel_q;
      OFS_DIR:   hst_rdata[0] = dir_q;
      OFS_SIZE:  hst_rdata[1:0] = size_q;
      OFS_ADDR:  hst_rdata[DNAW-1:0] = addr_q;
      OFS_WDAT:  hst_rdata = wdat_q;
      OFS_CSYNC: hst_rdata[0] = csync_q;
      OFS_IMSK:  hst_rdata[IRQ_CH0_BIT] = imsk_q;
      OFS_ISTA:  hst_rdata[IRQ_CH0_BIT] = ista_q;
      OFS_RTRY:  hst_rdata[RCW-1:0] = rlim_q;
      OFS_STAT: begin
        hst_rdata[DW-1]   = busy;
        hst_rdata[ST_W-1:0] = stat_q;
      end
      OFS_RDAT:  hst_rdata = rdat_q;
      default:   hst_rdata = '0;
    endcase
  end

  AST_XFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> $stable(dn_addr) && $stable(dn_wdata)
                          && $stable(dn_rnw) && $stable(dn_size)); // R3
  AST_BUSY_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && we_trig |=> $stable(dn_addr) && $stable(dn_rnw)); // R4
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_q[ST_ERR:ST_HALF])); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !we_trig |=> $stable(stat_q) && $stable(rdat_q)); // R8
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_ack && dn_resp != RSP_RETRY |=> ista_q); // R9
endmodule

// File: tb/xact_bridge_test.sv
`timescale 1ns/1ps
module xact_bridge_test;
  import xb_pkg::*;

  localparam logic [31:0] EXP_VER = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        hst_wr = 1'b0;
  logic [7:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        irq, dn_req, dn_rnw;
  logic [1:0]  dn_size;
  logic [31:0] dn_addr, dn_wdata;
  logic        dn_ack = 1'b0;
  logic [1:0]  dn_resp = '0;
  logic [31:0] dn_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  xact_bridge #(.VERSION(EXP_VER)) uut (
    .clk(clk), .arst_n(arst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq),
    .dn_req(dn_req), .dn_rnw(dn_rnw), .dn_size(dn_size), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_resp(dn_resp), .dn_rdata(dn_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_addr = a;
    #1;
    d = hst_rdata;
  endtask

  task automatic respond(input logic [1:0] r, input logic [31:0] d);
    while (!dn_req) @(negedge clk);
    dn_ack = 1'b1; dn_resp = r; dn_rdata = d;
    @(negedge clk);
    dn_ack = 1'b0; dn_resp = '0;
  endtask

  task automatic stage(input logic dir, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] d);
    wr(OFS_DIR, {31'd0, dir});
    wr(OFS_SIZE, {30'd0, sz});
    wr(OFS_ADDR, a);
    wr(OFS_WDAT, d);
    wr(OFS_ICLR, 32'd1);
  endtask

  function automatic logic [31:0] zext(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'd0)      return d & 32'h0000_00FF;
    else if (sz == 2'd1) return d & 32'h0000_FFFF;
    else                 return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 dn_req", {31'd0, dn_req}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(OFS_VER, v);  chk("R1 version", v, EXP_VER);
    rd(OFS_STAT, v); chk("R1 status", v, 32'd0);
    rd(OFS_RDAT, v); chk("R1 rdata", v, 32'd0);
    rd(OFS_ISTA, v); chk("R1 irq status", v, 32'd0);
    rd(OFS_IMSK, v); chk("R1 irq mask", v, 32'd0);
    rd(OFS_ADDR, v); chk("R1 addr", v, 32'd0);

    // R2 register readback, R10 bit 17 absent
    begin
      logic [7:0]  ofs [10];
      logic [31:0] msk [10];
      ofs = '{OFS_CBASE, OFS_LBASE, OFS_SEL, OFS_DIR, OFS_SIZE,
              OFS_ADDR, OFS_WDAT, OFS_CSYNC, OFS_IMSK, OFS_RTRY};
      msk = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 32'h1, 32'h3,
              32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 32'h0001_0000, 32'hFF};
      for (int i = 0; i < 10; i++) begin
        wr(ofs[i], 32'hFFFF_FFFF);
        rd(ofs[i], v); chk("R2 readback ones", v, msk[i]);
        wr(ofs[i], 32'h5A5A_A5A5);
        rd(ofs[i], v); chk("R2 readback pattern", v, 32'h5A5A_A5A5 & msk[i]);
      end
      rd(8'h7C, v); chk("R2 unmapped", v, 32'd0);
      wr(OFS_IMSK, 32'hFFFF_FFFF);
      rd(OFS_IMSK, v); chk("R10 mask bit17", v & 32'h0002_0000, 32'd0);
    end

    wr(OFS_SEL, 32'd1);
    wr(OFS_RTRY, 32'd0);

    // main sweep: direction x size x ok/error
    for (int dir = 0; dir < 2; dir++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int rs = 0; rs < 2; rs++) begin
          logic [31:0] a, d, rdw, exp_st, exp_rd;
          logic mk;
          a   = 32'h4000_0000 + 32'(dir * 64 + sz * 8 + rs * 4);
          d   = 32'hC3A5_0000 | 32'(dir * 4096 + sz * 256 + rs * 17);
          rdw = 32'h9E37_79B9 ^ a;
          mk  = sz[0];
          wr(OFS_IMSK, {15'd0, mk, 16'd0});
          stage(dir[0], sz[1:0], a, d);
          wr(OFS_TRIG, 32'd1);
          chk("R3 request fields",
              {dn_req, dn_rnw, dn_size, 28'd0},
              {1'b1, dir[0], sz[1:0], 28'd0});
          chk("R3 address", dn_addr, a);
          chk("R3 write data", dn_wdata, d);
          rd(OFS_STAT, v); chk("R5 busy", v & 32'h8000_0000, 32'h8000_0000);
          respond(rs[1:0], rdw);
          exp_st = (rs == 1) ? 32'h4 : ((sz >= 2) ? 32'h2 : 32'h1);
          exp_rd = (dir == 1 && rs == 0) ? zext(sz[1:0], rdw) : 32'd0;
          rd(OFS_STAT, v); chk("R6 status", v, exp_st);
          rd(OFS_RDAT, v); chk("R8 read data", v, exp_rd);
          rd(OFS_ISTA, v); chk("R9 irq status", v, 32'h0001_0000);
          chk("R10 irq", {31'd0, irq}, {31'd0, mk});
        end
      end
    end

    // R8 hold after completion: last was read, size 3, error -> rdata 0; do ok read then rewrite staging
    wr(OFS_IMSK, 32'h0001_0000);
    stage(1'b1, 2'd1, 32'h0000_1234, 32'd0);
    wr(OFS_TRIG, 32'd1);
    respond(RSP_OK, 32'hDEAD_BEEF);
    wr(OFS_SIZE, 32'd3);
    wr(OFS_ADDR, 32'h0BAD_0BAD);
    rd(OFS_RDAT, v); chk("R8 hold rdata", v, 32'h0000_BEEF);
    rd(OFS_STAT, v); chk("R8 hold status", v, 32'h1);

    // R4 select clear
    wr(OFS_SEL, 32'd0);
    wr(OFS_TRIG, 32'd1);
    @(negedge clk);
    chk("R4 select off no req", {31'd0, dn_req}, 32'd0);
    rd(OFS_STAT, v); chk("R4 select off status held", v, 32'h1);
    wr(OFS_SEL, 32'd1);
    wr(OFS_TRIG, 32'd2);
    @(negedge clk);
    chk("R4 bit0 clear no req", {31'd0, dn_req}, 32'd0);
    rd(OFS_RDAT, v); chk("R4 bit0 clear rdata held", v, 32'h0000_BEEF);

    // R4 launch while busy
    stage(1'b0, 2'd3, 32'h1111_2222, 32'h3333_4444);
    wr(OFS_TRIG, 32'd1);
    wr(OFS_ADDR, 32'h5555_6666);
    wr(OFS_DIR, 32'd1);
    wr(OFS_TRIG, 32'd1);
    chk("R4 busy addr kept", dn_addr, 32'h1111_2222);
    chk("R4 busy dir kept", {31'd0, dn_rnw}, 32'd0);
    respond(RSP_OK, 32'd0);
    @(negedge clk);
    chk("R4 no second launch", {31'd0, dn_req}, 32'd0);
    rd(OFS_STAT, v); chk("R5 busy clear", v, 32'h2);

    // R7 retry sweep
    wr(OFS_DIR, 32'd1);
    wr(OFS_SIZE, 32'd3);
    for (int lim = 0; lim < 4; lim++) begin
      for (int nr = 0; nr <= lim + 1; nr++) begin
        logic [31:0] exp_st;
        wr(OFS_RTRY, 32'(lim));
        wr(OFS_ICLR, 32'd1);
        wr(OFS_TRIG, 32'd1);
        for (int k = 1; k <= nr; k++) begin
          respond(RSP_RETRY, 32'd0);
          chk("R7 request dropped after retry", {31'd0, dn_req}, 32'd0);
          if (k <= lim) begin
            @(negedge clk);
            chk("R7 reissue", {31'd0, dn_req}, 32'd1);
          end
        end
        if (nr <= lim) begin
          respond(RSP_OK, 32'h0F0F_0000 | 32'(nr));
          exp_st = (nr > 0) ? 32'hA : 32'h2;
          rd(OFS_RDAT, v); chk("R7 read after retries", v, 32'h0F0F_0000 | 32'(nr));
        end else begin
          exp_st = 32'h18;
        end
        rd(OFS_STAT, v); chk("R7 status", v, exp_st);
        rd(OFS_ISTA, v); chk("R7 completion", v, 32'h0001_0000);
      end
    end

    // R9 clear write in the same cycle as completion
    wr(OFS_RTRY, 32'd0);
    wr(OFS_ICLR, 32'd1);
    wr(OFS_TRIG, 32'd1);
    while (!dn_req) @(negedge clk);
    dn_ack = 1'b1; dn_resp = RSP_OK;
    hst_wr = 1'b1; hst_addr = OFS_ICLR; hst_wdata = 32'd1;
    @(negedge clk);
    dn_ack = 1'b0; hst_wr = 1'b0;
    rd(OFS_ISTA, v); chk("R9 set wins over clear", v, 32'h0001_0000);
    chk("R10 irq on", {31'd0, irq}, 32'd1);
    wr(OFS_ICLR, 32'h0001_0000);
    rd(OFS_ISTA, v); chk("R9 clear needs bit0", v, 32'h0001_0000);
    wr(OFS_ICLR, 32'd1);
    rd(OFS_ISTA, v); chk("R9 cleared", v, 32'd0);
    chk("R10 irq off", {31'd0, irq}, 32'd0);

    summary();
  end
endmodule